// File: doc/BRIEF.md
# March-Test Memory Self-Test Sequencer

This block drives one SRAM through a short program of march instructions and runs at one memory operation per clock. The address space is two-dimensional: a row address and a column address, each with an inclusive upper limit set at run time. A one-bit setting picks which of the two advances in the inner loop. A march instruction has up to four read or write operations and runs them all at each address before it moves on. It walks the space upward from (0,0) or downward from (max row, max column). Each operation names one of eight data words in a pattern table held in flip-flops, and may invert that word bit by bit. A wait instruction idles the engine for a given number of cycles.

Software, or a scan path, loads the program, the limits and any custom pattern words. It then holds start for one or more cycles to clear the engine, raises enable, and keeps enable high until done. The engine stops at one of three points: at the first read whose data differs from the expected word, at the end of the program, or when its 32-bit cycle counter reaches the configured budget. On a miscompare it holds the failing instruction index, the address, the expected word, the received word and the cycle number.

The SRAM request port has no back-pressure. The memory must accept one request per cycle and return read data on the cycle after the read request. Control and status pins are plain levels.

Top module: `mbist_seq`

## Requirements
- R1: After reset, done_o, fail_o and sram_en_o are all 0.
- R2: Each program slot is 25 bits wide. Bits [1:0] hold the kind: 1 is march, 2 is wait, and 0 or 3 ends the program. Bit [2] holds the direction (1 = down). Bits [4:3] hold the operation count minus one. Operation k sits at bits [5+5k +: 5] as {write, invert, pattern index[2:0]}. A fault-free run issues exactly one SRAM request per cycle for every operation, for example 5n for MATS+ or 10n for March C- with n addresses. It then ends with done_o=1 and fail_o=0.
- R3: When inner_row_i=1 the row address advances fastest; when it is 0 the column advances fastest. UP starts at (0,0) and DOWN starts at (max_row_i, max_col_i). All operations of an instruction are issued at one address before the address moves.
- R4: After reset the pattern table holds, from index 0 to 7: all zeros, all ones, 0x5…5, 0xA…A, 0x5…5, 0x3…3, 0xC…C, and all zeros. Writing through pat_we_i/pat_idx_i/pat_data_i replaces one entry.
- R5: When the invert bit of an operation is set, the engine writes, or expects on a read, the bitwise complement of the pattern entry that operation names.
- R6: When the read data on the cycle after a read request differs from the expected word, fail_o and done_o rise and no further SRAM request is issued.
- R7: On the first miscompare the engine latches the instruction index, the row, the column, the expected word, the received word, and the 0-based count of run cycles before the failing read.
- R8: The engine never issues more SRAM requests than cycle_limit_i in one run. When the limit is reached it stops with done_o=1, and a limit of 0 issues nothing.
- R9: A wait instruction with count c idles the engine for c cycles (c=0 acts as 1) before the next instruction.
- R10: A start pulse clears done_o, fail_o and all counters, so the program can run again.
- R11: While en_i is low no SRAM request is issued, and the run resumes where it stopped when en_i rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears counters and status |
| en_i | input | 1 | Run enable; hold high until done |
| max_row_i | input | ROW_W | Highest row address, inclusive |
| max_col_i | input | COL_W | Highest column address, inclusive |
| inner_row_i | input | 1 | 1: row is the inner loop; 0: column is the inner loop |
| prog_i | input | N_INST*25 | Instruction slots, slot 0 in the low bits |
| pat_we_i | input | 1 | Pattern table write strobe |
| pat_idx_i | input | 3 | Pattern entry to write |
| pat_data_i | input | DATA_W | Pattern word to write |
| cycle_limit_i | input | 32 | Run-cycle budget |
| sram_en_o | output | 1 | SRAM request strobe |
| sram_we_o | output | 1 | 1 write, 0 read |
| sram_row_o | output | ROW_W | Row address |
| sram_col_o | output | COL_W | Column address |
| sram_wdata_o | output | DATA_W | Write data |
| sram_wmask_o | output | DATA_W | Write mask, all ones |
| sram_rdata_i | input | DATA_W | Read data, one cycle after the read |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Miscompare seen |
| fail_inst_o | output | PC_W | Failing instruction index |
| fail_row_o | output | ROW_W | Failing row |
| fail_col_o | output | COL_W | Failing column |
| fail_exp_o | output | DATA_W | Expected word |
| fail_got_o | output | DATA_W | Received word |
| fail_cycle_o | output | 32 | Run cycle of the failing read |

## Verification
The assertions check several things on every cycle. No request is issued while enable is low or after a fail. Every request address stays within the configured limits. The number of requests per run never exceeds the budget. Done holds until the next start, and a latched failure always has differing expected and received words. Other behaviour only the bench scenarios can show. These are the exact request counts of whole march programs, the order in which addresses are visited for each inner-loop choice and direction, and the default and overwritten pattern words. They also include the diagnostics after faults injected into a model memory at computed positions, and the timing of a wait.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int OPS_MAX = 4;
  localparam int PAT_IW  = 3;
  localparam int PAT_N   = 1 << PAT_IW;
  localparam int WAIT_W  = 20;
  localparam int INST_W  = 5 + OPS_MAX * (2 + PAT_IW);

  typedef enum logic [1:0] {
    K_END   = 2'd0,
    K_MARCH = 2'd1,
    K_WAIT  = 2'd2,
    K_HALT  = 2'd3
  } kind_e;

  typedef struct packed {
    logic              wr;
    logic              inv;
    logic [PAT_IW-1:0] pat;
  } mop_t;

  typedef struct packed {
    mop_t [OPS_MAX-1:0] ops;
    logic [1:0]         cnt_m1;
    logic               down;
    kind_e              kind;
  } minst_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RUN   = 2'd1,
    S_DRAIN = 2'd2,
    S_DONE  = 2'd3
  } state_e;
endpackage

// File: rtl/mbist_pat.sv
module mbist_pat
  import mbist_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [PAT_IW-1:0] widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PAT_IW-1:0] ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  function automatic logic [DATA_W-1:0] rep4(input logic [3:0] nib);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++) w[i] = nib[i % 4];
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] reset_word(input int idx);
    case (idx)
      1:       return rep4(4'b1111);
      2, 4:    return rep4(4'b0101);
      3:       return rep4(4'b1010);
      5:       return rep4(4'b0011);
      6:       return rep4(4'b1100);
      default: return rep4(4'b0000);
    endcase
  endfunction

  logic [DATA_W-1:0] tbl [PAT_N];

  for (genvar g = 0; g < PAT_N; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl[g] <= reset_word(g);
      else if (we_i && (widx_i == PAT_IW'(g))) tbl[g] <= wdata_i;
    end
  end

  assign rdata_o = tbl[ridx_i];
endmodule

// File: rtl/mbist_addr.sv
module mbist_addr #(
  parameter int ROW_W = 10,
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             load_down_i,
  input  logic             step_i,
  input  logic             down_i,
  input  logic             inner_row_i,
  input  logic [ROW_W-1:0] max_row_i,
  input  logic [COL_W-1:0] max_col_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [ROW_W-1:0] row_q, row_n, row_wrap, row_inc;
  logic [COL_W-1:0] col_q, col_n, col_wrap, col_inc;
  logic             row_end, col_end;

  always_comb begin
    row_end  = down_i ? (row_q == '0) : (row_q == max_row_i);
    col_end  = down_i ? (col_q == '0) : (col_q == max_col_i);
    row_wrap = down_i ? max_row_i : '0;
    col_wrap = down_i ? max_col_i : '0;
    row_inc  = down_i ? row_q - 1'b1 : row_q + 1'b1;
    col_inc  = down_i ? col_q - 1'b1 : col_q + 1'b1;
    if (inner_row_i) begin
      row_n = row_end ? row_wrap : row_inc;
      col_n = row_end ? col_inc : col_q;
    end else begin
      col_n = col_end ? col_wrap : col_inc;
      row_n = col_end ? row_inc : row_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load_i) begin
      row_q <= load_down_i ? max_row_i : '0;
      col_q <= load_down_i ? max_col_i : '0;
    end else if (step_i) begin
      row_q <= row_n;
      col_q <= col_n;
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign last_o = row_end && col_end;
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 3,
  parameter int PC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rd_issue_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [PC_W-1:0]   inst_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [31:0]       cyc_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              mis_o,
  output logic              fail_o,
  output logic [PC_W-1:0]   fail_inst_o,
  output logic [ROW_W-1:0]  fail_row_o,
  output logic [COL_W-1:0]  fail_col_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o,
  output logic [31:0]       fail_cycle_o
);
  logic              pv;
  logic [DATA_W-1:0] pexp;
  logic [PC_W-1:0]   pinst;
  logic [ROW_W-1:0]  prow;
  logic [COL_W-1:0]  pcol;
  logic [31:0]       pcyc;

  assign mis_o = pv && (rdata_i != pexp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= 1'b0; pexp <= '0; pinst <= '0; prow <= '0; pcol <= '0; pcyc <= '0;
    end else begin
      pv <= rd_issue_i && !clear_i;
      if (rd_issue_i) begin
        pexp <= exp_i; pinst <= inst_i; prow <= row_i; pcol <= col_i; pcyc <= cyc_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_o <= 1'b0; fail_inst_o <= '0; fail_row_o <= '0; fail_col_o <= '0;
      fail_exp_o <= '0; fail_got_o <= '0; fail_cycle_o <= '0;
    end else if (clear_i) begin
      fail_o <= 1'b0;
    end else if (mis_o && !fail_o) begin
      fail_o       <= 1'b1;
      fail_inst_o  <= pinst;
      fail_row_o   <= prow;
      fail_col_o   <= pcol;
      fail_exp_o   <= pexp;
      fail_got_o   <= rdata_i;
      fail_cycle_o <= pcyc;
    end
  end
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int N_INST = 8,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 3,
  parameter int DATA_W = 32,
  localparam int PC_W  = $clog2(N_INST) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     en_i,
  input  logic [ROW_W-1:0]         max_row_i,
  input  logic [COL_W-1:0]         max_col_i,
  input  logic                     inner_row_i,
  input  logic [N_INST*INST_W-1:0] prog_i,
  input  logic                     pat_we_i,
  input  logic [PAT_IW-1:0]        pat_idx_i,
  input  logic [DATA_W-1:0]        pat_data_i,
  input  logic [31:0]              cycle_limit_i,
  output logic                     sram_en_o,
  output logic                     sram_we_o,
  output logic [ROW_W-1:0]         sram_row_o,
  output logic [COL_W-1:0]         sram_col_o,
  output logic [DATA_W-1:0]        sram_wdata_o,
  output logic [DATA_W-1:0]        sram_wmask_o,
  input  logic [DATA_W-1:0]        sram_rdata_i,
  output logic                     done_o,
  output logic                     fail_o,
  output logic [PC_W-1:0]          fail_inst_o,
  output logic [ROW_W-1:0]         fail_row_o,
  output logic [COL_W-1:0]         fail_col_o,
  output logic [DATA_W-1:0]        fail_exp_o,
  output logic [DATA_W-1:0]        fail_got_o,
  output logic [31:0]              fail_cycle_o
);
  state_e            state;
  logic [PC_W-1:0]   pc;
  logic [1:0]        opi;
  logic [WAIT_W-1:0] wcnt;
  logic [31:0]       cyc;

  minst_t            cur;
  mop_t              op;
  logic [DATA_W-1:0] pat_word, op_word;
  logic              is_march, is_wait, last_op, wait_fin, hit_limit, mis;
  logic              run_ok, issue, adv_inst, step, addr_last, ld, ld_down;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;

  // Out-of-range slots read as an end instruction.
  function automatic minst_t fetch(input logic [PC_W-1:0] idx);
    if (int'(idx) < N_INST) return minst_t'(prog_i[int'(idx)*INST_W +: INST_W]);
    return '0;
  endfunction

  always_comb begin
    cur       = fetch(pc);
    op        = cur.ops[opi];
    op_word   = pat_word ^ {DATA_W{op.inv}};
    is_march  = (cur.kind == K_MARCH);
    is_wait   = (cur.kind == K_WAIT);
    last_op   = (opi == cur.cnt_m1);
    wait_fin  = ({1'b0, wcnt} + 1'b1) >= {1'b0, WAIT_W'(cur.ops)};
    hit_limit = (cyc == cycle_limit_i);
    run_ok    = (state == S_RUN) && en_i && !start_i && !mis && !hit_limit;
    issue     = run_ok && is_march;
    adv_inst  = run_ok && ((is_march && last_op && addr_last) || (is_wait && wait_fin));
    step      = issue && last_op && !addr_last;
    ld        = start_i || adv_inst;
    ld_down   = start_i ? fetch('0).down : fetch(pc + 1'b1).down;
  end

  mbist_pat #(.DATA_W(DATA_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .we_i(pat_we_i), .widx_i(pat_idx_i),
    .wdata_i(pat_data_i), .ridx_i(op.pat), .rdata_o(pat_word)
  );

  mbist_addr #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .load_down_i(ld_down), .step_i(step),
    .down_i(cur.down), .inner_row_i(inner_row_i), .max_row_i(max_row_i),
    .max_col_i(max_col_i), .row_o(row), .col_o(col), .last_o(addr_last)
  );

  mbist_cmp #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W), .PC_W(PC_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .rd_issue_i(issue && !op.wr),
    .exp_i(op_word), .inst_i(pc), .row_i(row), .col_i(col), .cyc_i(cyc),
    .rdata_i(sram_rdata_i), .mis_o(mis), .fail_o(fail_o), .fail_inst_o(fail_inst_o),
    .fail_row_o(fail_row_o), .fail_col_o(fail_col_o), .fail_exp_o(fail_exp_o),
    .fail_got_o(fail_got_o), .fail_cycle_o(fail_cycle_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; pc <= '0; opi <= '0; wcnt <= '0; cyc <= '0;
    end else if (start_i) begin
      state <= S_IDLE; pc <= '0; opi <= '0; wcnt <= '0; cyc <= '0;
    end else begin
      case (state)
        S_IDLE: if (en_i) state <= S_RUN;
        S_RUN: begin
          if (mis) begin
            state <= S_DONE;
          end else if (en_i) begin
            if (hit_limit || !(is_march || is_wait)) begin
              state <= S_DRAIN;
            end else begin
              cyc <= cyc + 1'b1;
              if (is_march) opi <= last_op ? 2'd0 : opi + 1'b1;
              else          wcnt <= wait_fin ? '0 : wcnt + 1'b1;
              if (adv_inst) pc <= pc + 1'b1;
            end
          end
        end
        S_DRAIN: state <= S_DONE;
        default: ;
      endcase
    end
  end

  assign sram_en_o    = issue;
  assign sram_we_o    = issue && op.wr;
  assign sram_row_o   = row;
  assign sram_col_o   = col;
  assign sram_wdata_o = op_word;
  assign sram_wmask_o = {DATA_W{1'b1}};
  assign done_o       = (state == S_DONE);
endmodule

module mbist_seq_chk #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              en_i,
  input logic [ROW_W-1:0]  max_row_i,
  input logic [COL_W-1:0]  max_col_i,
  input logic [31:0]       cycle_limit_i,
  input logic              sram_en_o,
  input logic [ROW_W-1:0]  sram_row_o,
  input logic [COL_W-1:0]  sram_col_o,
  input logic              done_o,
  input logic              fail_o,
  input logic [DATA_W-1:0] fail_exp_o,
  input logic [DATA_W-1:0] fail_got_o
);
  logic [32:0] req_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req_cnt <= '0;
    else if (start_i)   req_cnt <= '0;
    else if (sram_en_o) req_cnt <= req_cnt + 1'b1;
  end

  // R11
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en_o |-> en_i);
  // R6
  halt_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (done_o && !sram_en_o));
  // R3
  addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en_o |-> (sram_row_o <= max_row_i && sram_col_o <= max_col_i));
  // R8
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_en_o |-> (req_cnt < {1'b0, cycle_limit_i}));
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
  // R7
  diag_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> (fail_exp_o != fail_got_o));
endmodule

bind mbist_seq mbist_seq_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .en_i(en_i), .max_row_i(max_row_i),
  .max_col_i(max_col_i), .cycle_limit_i(cycle_limit_i), .sram_en_o(sram_en_o),
  .sram_row_o(sram_row_o), .sram_col_o(sram_col_o), .done_o(done_o), .fail_o(fail_o),
  .fail_exp_o(fail_exp_o), .fail_got_o(fail_got_o)
);

// File: tb/mbist_seq_tb.sv
module mbist_seq_tb;
  import mbist_pkg::*;
  localparam int N_INST = 8, ROW_W = 10, COL_W = 3, DATA_W = 32, PC_W = 4;

  typedef struct packed {
    logic       march_c;
    logic [3:0] mrow;
    logic [2:0] mcol;
    logic       inner_row;
    logic       fault;
    logic       sval;
    logic [3:0] frow;
    logic [2:0] fcol;
    logic [4:0] fbit;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{1'b0, 4'd3, 3'd1, 1'b1, 1'b0, 1'b0, 4'd0, 3'd0, 5'd0},
    '{1'b1, 4'd2, 3'd2, 1'b0, 1'b0, 1'b0, 4'd0, 3'd0, 5'd0},
    '{1'b0, 4'd3, 3'd1, 1'b1, 1'b1, 1'b1, 4'd2, 3'd1, 5'd7},
    '{1'b0, 4'd3, 3'd1, 1'b0, 1'b1, 1'b1, 4'd2, 3'd1, 5'd7},
    '{1'b0, 4'd1, 3'd3, 1'b1, 1'b1, 1'b0, 4'd0, 3'd2, 5'd31},
    '{1'b1, 4'd2, 3'd2, 1'b0, 1'b1, 1'b1, 4'd1, 3'd1, 5'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, en = 1'b0, inner_row = 1'b1;
  logic [ROW_W-1:0] max_row = '0;
  logic [COL_W-1:0] max_col = '0;
  logic [INST_W-1:0] pw [N_INST];
  logic [N_INST*INST_W-1:0] prog;
  logic pat_we = 1'b0;
  logic [2:0] pat_idx = '0;
  logic [DATA_W-1:0] pat_data = '0;
  logic [31:0] limit = 32'hFFFF_FFFF;
  logic sram_en, sram_we, done, fail;
  logic [ROW_W-1:0] srow, frow_o;
  logic [COL_W-1:0] scol, fcol_o;
  logic [DATA_W-1:0] wdata, wmask, rdata = '0, fexp, fgot;
  logic [PC_W-1:0] finst;
  logic [31:0] fcyc;

  for (genvar g = 0; g < N_INST; g++) begin : g_prog
    assign prog[g*INST_W +: INST_W] = pw[g];
  end

  always #5 clk = ~clk;

  mbist_seq #(.N_INST(N_INST), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .en_i(en), .max_row_i(max_row),
    .max_col_i(max_col), .inner_row_i(inner_row), .prog_i(prog), .pat_we_i(pat_we),
    .pat_idx_i(pat_idx), .pat_data_i(pat_data), .cycle_limit_i(limit),
    .sram_en_o(sram_en), .sram_we_o(sram_we), .sram_row_o(srow), .sram_col_o(scol),
    .sram_wdata_o(wdata), .sram_wmask_o(wmask), .sram_rdata_i(rdata), .done_o(done),
    .fail_o(fail), .fail_inst_o(finst), .fail_row_o(frow_o), .fail_col_o(fcol_o),
    .fail_exp_o(fexp), .fail_got_o(fgot), .fail_cycle_o(fcyc)
  );

  // Behavioural SRAM with one injectable stuck-at bit
  logic [DATA_W-1:0] mem [0:127];
  logic f_en = 1'b0, f_val = 1'b0;
  logic [3:0] f_row = '0;
  logic [2:0] f_col = '0;
  logic [4:0] f_bit = '0;
  wire  [6:0] maddr = {srow[3:0], scol};

  always @(posedge clk) begin
    if (sram_en) begin
      if (sram_we) mem[maddr] <= (wdata & wmask) | (mem[maddr] & ~wmask);
      else begin
        logic [DATA_W-1:0] w;
        w = mem[maddr];
        if (f_en && maddr == {f_row, f_col}) w[f_bit] = f_val;
        rdata <= w;
      end
    end
  end

  // Request monitor
  int ops = 0, tb_cyc = 0, first_op = -1, ops_low = 0;
  logic [ROW_W-1:0] a_row [4];
  logic [COL_W-1:0] a_col [4];
  logic [DATA_W-1:0] a_wd [4];
  always @(negedge clk) begin
    if (en) tb_cyc++;
    if (sram_en) begin
      if (ops < 4) begin a_row[ops] = srow; a_col[ops] = scol; a_wd[ops] = wdata; end
      if (first_op < 0) first_op = tb_cyc;
      if (!en) ops_low++;
      ops++;
    end
  end

  int nchk = 0, nerr = 0;
  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [4:0] mop(input bit w, input bit inv, input int p);
    return {w, inv, 3'(p)};
  endfunction
  function automatic logic [INST_W-1:0] march(input bit down, input int n,
      input logic [4:0] o0, input logic [4:0] o1 = '0, input logic [4:0] o2 = '0, input logic [4:0] o3 = '0);
    return {o3, o2, o1, o0, 2'(n - 1), down, 2'd1};
  endfunction
  function automatic logic [INST_W-1:0] waitc(input int n);
    return {20'(n), 3'b000, 2'd2};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < N_INST; i++) pw[i] = '0;
  endtask
  task automatic load_mats();
    clear_prog();
    pw[0] = march(0, 1, mop(1, 0, 0));
    pw[1] = march(0, 2, mop(0, 0, 0), mop(1, 0, 1));
    pw[2] = march(1, 2, mop(0, 0, 1), mop(1, 0, 0));
  endtask
  task automatic load_marchc();
    clear_prog();
    pw[0] = march(0, 1, mop(1, 0, 0));
    pw[1] = march(0, 2, mop(0, 0, 0), mop(1, 0, 1));
    pw[2] = march(0, 2, mop(0, 0, 1), mop(1, 0, 0));
    pw[3] = march(1, 2, mop(0, 0, 0), mop(1, 0, 1));
    pw[4] = march(1, 2, mop(0, 0, 1), mop(1, 0, 0));
    pw[5] = march(0, 1, mop(0, 0, 0));
  endtask

  task automatic do_start();
    @(posedge clk); #1 start = 1'b1; en = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1 start = 1'b0; ops = 0; tb_cyc = 0; first_op = -1; ops_low = 0; en = 1'b1;
  endtask
  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
    chk(req, "done reached", 64'(seen), 64'd1);
    @(posedge clk); #1 en = 1'b0;
  endtask
  task automatic run(input string req);
    do_start();
    wait_done(req);
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int n, k, ecyc, einst;
    logic [DATA_W-1:0] eexp, egot;
    vec_t t;
    clear_prog();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", 64'(done), 64'd0);
    chk("R1", "fail after reset", 64'(fail), 64'd0);
    chk("R1", "sram_en after reset", 64'(sram_en), 64'd0);

    // Vector table: march programs with and without faults
    for (int v = 0; v < 6; v++) begin
      t = VEC[v];
      max_row = ROW_W'(t.mrow); max_col = t.mcol; inner_row = t.inner_row;
      f_en = t.fault; f_val = t.sval; f_row = t.frow; f_col = t.fcol; f_bit = t.fbit;
      if (t.march_c) load_marchc(); else load_mats();
      run("R2");
      n = (int'(t.mrow) + 1) * (int'(t.mcol) + 1);
      if (!t.fault) begin
        chk("R2", "fault-free fail", 64'(fail), 64'd0);
        chk("R2", "request count", 64'(ops), 64'((t.march_c ? 10 : 5) * n));
      end else begin
        k = t.inner_row ? int'(t.fcol) * (int'(t.mrow) + 1) + int'(t.frow)
                        : int'(t.frow) * (int'(t.mcol) + 1) + int'(t.fcol);
        if (t.sval) begin
          ecyc = n + 2 * k; einst = 1; eexp = '0; egot = DATA_W'(1) << t.fbit;
        end else begin
          ecyc = t.march_c ? 3 * n + 2 * k : 3 * n + 2 * (n - 1 - k);
          einst = 2; eexp = '1; egot = ~(DATA_W'(1) << t.fbit);
        end
        chk("R6", "fail flag", 64'(fail), 64'd1);
        chk("R6", "requests stop after failing read", 64'(ops), 64'(ecyc + 1));
        chk("R7", "fail instruction", 64'(finst), 64'(einst));
        chk("R7", "fail row", 64'(frow_o), 64'(t.frow));
        chk("R7", "fail col", 64'(fcol_o), 64'(t.fcol));
        chk("R7", "expected word", 64'(fexp), 64'(eexp));
        chk("R7", "received word", 64'(fgot), 64'(egot));
        chk("R7", "fail cycle", 64'(fcyc), 64'(ecyc));
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        chk("R10", "done cleared by start", 64'(done), 64'd0);
        chk("R10", "fail cleared by start", 64'(fail), 64'd0);
      end
      f_en = 1'b0;
    end

    // R4 + R3: default patterns 5 and 6, both ops at one address first
    clear_prog();
    pw[0] = march(0, 2, mop(1, 0, 5), mop(1, 0, 6));
    max_row = 1; max_col = 0; inner_row = 1'b1;
    run("R4");
    chk("R4", "default entry 5", 64'(a_wd[0]), 64'h3333_3333);
    chk("R4", "default entry 6", 64'(a_wd[1]), 64'hCCCC_CCCC);
    chk("R3", "second op same row", 64'(a_row[1]), 64'd0);
    chk("R3", "address moves after list", 64'(a_row[2]), 64'd1);

    // R3: inner loop selection and DOWN start
    clear_prog();
    pw[0] = march(0, 1, mop(1, 0, 0));
    max_row = 1; max_col = 1; inner_row = 1'b1;
    run("R3");
    chk("R3", "row-inner second address", 64'({a_row[1], a_col[1]}), 64'({10'd1, 3'd0}));
    inner_row = 1'b0;
    run("R3");
    chk("R3", "col-inner second address", 64'({a_row[1], a_col[1]}), 64'({10'd0, 3'd1}));
    pw[0] = march(1, 1, mop(1, 0, 0));
    max_row = 2; inner_row = 1'b1;
    run("R3");
    chk("R3", "DOWN first address", 64'({a_row[0], a_col[0]}), 64'({10'd2, 3'd1}));
    chk("R3", "DOWN second address", 64'({a_row[1], a_col[1]}), 64'({10'd1, 3'd1}));

    // R4 + R5: overwritten entry 7, read back inverted
    @(posedge clk); #1 pat_we = 1'b1; pat_idx = 3'd7; pat_data = 32'hDEAD_BEEF;
    @(posedge clk); #1 pat_we = 1'b0;
    clear_prog();
    pw[0] = march(0, 1, mop(1, 0, 7));
    pw[1] = march(0, 1, mop(0, 1, 7));
    max_row = 1; max_col = 0;
    run("R5");
    chk("R4", "written entry 7", 64'(a_wd[0]), 64'hDEAD_BEEF);
    chk("R5", "inverted read miscompare", 64'(fail), 64'd1);
    chk("R5", "inverted expected word", 64'(fexp), 64'h2152_4110);
    chk("R5", "received word", 64'(fgot), 64'hDEAD_BEEF);
    chk("R7", "fail cycle at first read", 64'(fcyc), 64'd2);

    // R8: cycle budget
    load_mats(); max_row = 3; max_col = 1; limit = 7;
    run("R8");
    chk("R8", "requests under budget 7", 64'(ops), 64'd7);
    chk("R8", "no fail under budget", 64'(fail), 64'd0);
    limit = 0;
    run("R8");
    chk("R8", "zero budget issues nothing", 64'(ops), 64'd0);
    limit = 32'hFFFF_FFFF;

    // R9: wait shifts the first request by its count
    begin
      int base;
      clear_prog();
      pw[0] = march(0, 1, mop(1, 0, 0));
      max_row = 0; max_col = 0;
      run("R9");
      base = first_op;
      pw[0] = waitc(5);
      pw[1] = march(0, 1, mop(1, 0, 0));
      run("R9");
      chk("R9", "wait 5 delay", 64'(first_op - base), 64'd5);
      chk("R9", "one request after wait", 64'(ops), 64'd1);
    end

    // R11: enable low pauses, run resumes and completes
    load_mats(); max_row = 3; max_col = 1; inner_row = 1'b1;
    do_start();
    repeat (4) @(posedge clk);
    #1 en = 1'b0;
    repeat (6) @(posedge clk);
    #1 en = 1'b1;
    wait_done("R11");
    chk("R11", "requests while enable low", 64'(ops_low), 64'd0);
    chk("R11", "full count after resume", 64'(ops), 64'd40);
    chk("R11", "no fail after resume", 64'(fail), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule